// File: doc/BRIEF.md
# Converter Input Channel Sequencer

This block turns an 8-bit control byte into the input selection of a four-input sampling converter. The byte carries an analog-output enable, a two-bit input configuration field, an auto-increment flag and a two-bit channel number. The configuration field fixes how the four inputs are paired, either as single-ended inputs or as differential pairs. Together with the channel number it fixes which inputs the front-end multiplexer routes to the converter's positive and negative sides.

The channel register loads when the load strobe is high. A channel number above the highest channel that the chosen configuration offers is clamped to that highest channel; it does not wrap. When auto-increment is set, each conversion-done strobe advances the channel by one. After the highest channel the next step is channel 0. The analog output enable also keeps the conversion clock running. All control pins are single-cycle strobes and plain levels, with no handshake: the sequencer never stalls, and every strobe takes effect at the clock edge where it is sampled.

Top module: `chseq_top`

## Requirements
- R1: After reset the channel is 0, the output enable is 0, auto-increment is off and the configuration is 00. The positive select is 0, the negative side is ground (`sel_gnd`=1) and `diff_mode`=0.
- R2: Field positions in `ctrl_byte`: bit 6 is the output enable, bits 5:4 the configuration, bit 2 auto-increment and bits 1:0 the channel. Bits 7 and 3 are ignored.
- R3: A control byte presented with `load`=1 takes effect at that clock edge. The outputs show it in the following cycle.
- R4: A requested channel above the highest channel of the configuration is clamped to that channel. The highest channel is 3 for configuration 00, 2 for 01, 2 for 10 and 1 for 11.
- R5: With auto-increment set, each `conv_done` pulse advances the channel by one.
- R6: With auto-increment set, a `conv_done` pulse on the highest channel moves the channel to 0.
- R7: With auto-increment clear, `conv_done` leaves the channel unchanged. With no strobe the channel holds.
- R8: When `load` and `conv_done` are high in the same cycle, the loaded channel wins.
- R9: Select codes. In configuration 00, channel n routes input n against ground. In configuration 01, channel n routes input n against input 3. In configuration 10, channels 0 and 1 route inputs 0 and 1 against ground, and channel 2 routes input 2 against input 3. In configuration 11, channel 0 routes input 0 against input 1, and channel 1 routes input 2 against input 3.
- R10: `diff_mode` is 1 exactly when the current selection is a differential pair, and then `sel_gnd` is 0 and the two select codes differ. For single-ended selections `sel_neg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_byte | input | 8 | Control byte |
| load | input | 1 | Load strobe for `ctrl_byte` |
| conv_done | input | 1 | Conversion-complete strobe |
| chan | output | 2 | Current channel number |
| diff_mode | output | 1 | Current selection is differential |
| sel_pos | output | 2 | Input routed to the positive side |
| sel_neg | output | 2 | Input routed to the negative side (0 when single-ended) |
| sel_gnd | output | 1 | Negative side tied to analog ground |
| out_en | output | 1 | Analog output and conversion clock enable |

## Verification
The assertions assume that `load` and `conv_done` are clean single-cycle levels sampled at the rising edge, and that `ctrl_byte` is valid whenever `load` is high. They make no assumption about how far apart strobes are, so back-to-back and coincident strobes are legal. The stimulus changes inputs only on falling edges and holds each strobe for one full cycle. It also drives `load` and `conv_done` together on purpose to cover the priority rule.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
  localparam int CH_W   = 2;
  localparam int CFG_W  = 2;
  localparam int BYTE_W = 8;

  typedef enum logic [CFG_W-1:0] {
    CFG_SE4   = 2'b00,
    CFG_DIFF3 = 2'b01,
    CFG_MIX   = 2'b10,
    CFG_DIFF2 = 2'b11
  } cfg_e;

  typedef struct packed {
    logic            rsv_hi;
    logic            out_en;
    cfg_e            cfg;
    logic            rsv_lo;
    logic            auto_inc;
    logic [CH_W-1:0] chan;
  } ctrl_t;

  function automatic logic [CH_W-1:0] top_chan(cfg_e c);
    case (c)
      CFG_SE4:   return CH_W'(3);
      CFG_DIFF3: return CH_W'(2);
      CFG_MIX:   return CH_W'(2);
      default:   return CH_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/chseq_ctrl_reg.sv
module chseq_ctrl_reg
  import chseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  ctrl_t ctrl_in,
  output cfg_e cfg_q,
  output logic out_en_q,
  output logic auto_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_SE4;
      out_en_q <= 1'b0;
      auto_q   <= 1'b0;
    end else if (load) begin
      cfg_q    <= ctrl_in.cfg;
      out_en_q <= ctrl_in.out_en;
      auto_q   <= ctrl_in.auto_inc;
    end
  end

  a_r2_en_follows_bit6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_en_q == $past(ctrl_in.out_en));
  a_r3_cfg_stable_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q) && $stable(out_en_q) && $stable(auto_q));
endmodule

// File: rtl/chseq_ctr.sv
module chseq_ctr
  import chseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_chan,
  input  logic            conv_done,
  input  logic            auto_en,
  input  logic [CH_W-1:0] top,
  output logic [CH_W-1:0] chan_q
);
  logic            step;
  logic [CH_W-1:0] chan_nxt;

  assign step = conv_done && auto_en;

  always_comb begin
    chan_nxt = chan_q;
    if (load)
      chan_nxt = load_chan;
    else if (step)
      chan_nxt = (chan_q >= top) ? '0 : chan_q + CH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= '0;
    else        chan_q <= chan_nxt;
  end

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    chan_q <= top);
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && conv_done && auto_en && chan_q < top) |=> chan_q == CH_W'($past(chan_q) + CH_W'(1)));
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && conv_done && auto_en && chan_q == top) |=> chan_q == '0);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(conv_done && auto_en)) |=> $stable(chan_q));
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> chan_q == $past(load_chan));
endmodule

// File: rtl/chseq_mux_dec.sv
module chseq_mux_dec
  import chseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_e            cfg,
  input  logic [CH_W-1:0] chan,
  output logic [CH_W-1:0] sel_pos,
  output logic [CH_W-1:0] sel_neg,
  output logic            sel_gnd,
  output logic            diff
);
  always_comb begin
    sel_pos = chan;
    sel_neg = '0;
    sel_gnd = 1'b1;
    diff    = 1'b0;
    case (cfg)
      CFG_SE4: ;
      CFG_DIFF3: begin
        sel_neg = CH_W'(3);
        sel_gnd = 1'b0;
        diff    = 1'b1;
      end
      CFG_MIX: begin
        if (chan == CH_W'(2)) begin
          sel_neg = CH_W'(3);
          sel_gnd = 1'b0;
          diff    = 1'b1;
        end
      end
      default: begin
        sel_pos = {chan[0], 1'b0};
        sel_neg = {chan[0], 1'b1};
        sel_gnd = 1'b0;
        diff    = 1'b1;
      end
    endcase
  end

  a_r10_pair_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    diff |-> (sel_pos != sel_neg) && !sel_gnd);
  a_r10_se_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !diff |-> sel_gnd && sel_neg == '0);
  a_r9_diff3_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == CFG_DIFF3) |-> sel_neg == CH_W'(3));
endmodule

// File: rtl/chseq_top.sv
module chseq_top
  import chseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BYTE_W-1:0]    ctrl_byte,
  input  logic                 load,
  input  logic                 conv_done,
  output logic [CH_W-1:0]      chan,
  output logic                 diff_mode,
  output logic [CH_W-1:0]      sel_pos,
  output logic [CH_W-1:0]      sel_neg,
  output logic                 sel_gnd,
  output logic                 out_en
);
  ctrl_t           ctrl;
  cfg_e            cfg_q;
  logic            auto_q;
  logic [CH_W-1:0] new_top;
  logic [CH_W-1:0] cur_top;
  logic [CH_W-1:0] load_chan;

  assign ctrl      = ctrl_t'(ctrl_byte);
  assign new_top   = top_chan(ctrl.cfg);
  assign cur_top   = top_chan(cfg_q);
  assign load_chan = (ctrl.chan > new_top) ? new_top : ctrl.chan;

  chseq_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .load(load), .ctrl_in(ctrl),
    .cfg_q(cfg_q), .out_en_q(out_en), .auto_q(auto_q)
  );

  chseq_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_chan(load_chan),
    .conv_done(conv_done), .auto_en(auto_q), .top(cur_top), .chan_q(chan)
  );

  chseq_mux_dec u_dec (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .chan(chan),
    .sel_pos(sel_pos), .sel_neg(sel_neg), .sel_gnd(sel_gnd), .diff(diff_mode)
  );

  a_r4_clamped_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ctrl_byte[1:0] > new_top) |=> chan == $past(new_top));
endmodule

// File: tb/sim_chseq_top.sv
module sim_chseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl_byte = '0;
  logic       load = 1'b0;
  logic       conv_done = 1'b0;
  logic [1:0] chan, sel_pos, sel_neg;
  logic       diff_mode, sel_gnd, out_en;
  int         errors = 0;
  int         checks = 0;

  always #2 clk = ~clk;

  chseq_top u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_byte(ctrl_byte), .load(load),
    .conv_done(conv_done), .chan(chan), .diff_mode(diff_mode),
    .sel_pos(sel_pos), .sel_neg(sel_neg), .sel_gnd(sel_gnd), .out_en(out_en)
  );

  // {ctrl, chan, pos, neg, gnd, diff, en}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h03, 2'd3, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h13, 2'd2, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0},
    {8'h11, 2'd1, 2'd1, 2'd3, 1'b0, 1'b1, 1'b0},
    {8'h20, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h21, 2'd1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'h23, 2'd2, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0},
    {8'h30, 2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0},
    {8'h33, 2'd1, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0},
    {8'h32, 2'd1, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0},
    {8'h41, 2'd1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1},
    {8'h88, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0},
    {8'hCB, 2'd3, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] b);
    @(negedge clk); ctrl_byte = b; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 chan", {6'd0, chan}, 8'd0);
    chk("R1 sel", {3'd0, sel_pos, sel_neg, sel_gnd}, {3'd0, 2'd0, 2'd0, 1'b1});
    chk("R1 en/diff", {6'd0, out_en, diff_mode}, 8'd0);
    do_done();
    chk("R1 auto off after reset", {6'd0, chan}, 8'd0);

    // R2 R3 R4 R9 R10 table walk
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][16:9]);
      chk("R3 R4 chan", {6'd0, chan}, {6'd0, VEC[i][8:7]});
      chk("R9 sel", {3'd0, sel_pos, sel_neg, sel_gnd}, {3'd0, VEC[i][6:2]});
      chk("R10 diff", {7'd0, diff_mode}, {7'd0, VEC[i][1]});
      chk("R2 en", {7'd0, out_en}, {7'd0, VEC[i][0]});
    end

    // R5 R6 auto-increment, four single-ended, start at 1
    do_load(8'h05);
    do_done(); chk("R5 step 1->2", {6'd0, chan}, 8'd2);
    do_done(); chk("R5 step 2->3", {6'd0, chan}, 8'd3);
    do_done(); chk("R6 wrap 3->0", {6'd0, chan}, 8'd0);
    // R6 clamped start then wrap: cfg 11 req 3 -> 1 -> 0
    do_load(8'h37);
    chk("R4 clamp cfg11", {6'd0, chan}, 8'd1);
    do_done(); chk("R6 wrap after clamp", {6'd0, chan}, 8'd0);
    chk("R9 cfg11 ch0", {3'd0, sel_pos, sel_neg, sel_gnd}, {3'd0, 2'd0, 2'd1, 1'b0});
    // cfg 01 wrap at 2
    do_load(8'h16);
    do_done(); chk("R6 wrap cfg01", {6'd0, chan}, 8'd0);
    // R2 reserved bit3 does not act as auto
    do_load(8'h09);
    do_done(); chk("R7 R2 bit3 ignored", {6'd0, chan}, 8'd1);
    // R7 hold with no strobe
    repeat (3) @(negedge clk);
    chk("R7 idle hold", {6'd0, chan}, 8'd1);
    // R8 priority
    do_load(8'h04);
    @(negedge clk); ctrl_byte = 8'h06; load = 1'b1; conv_done = 1'b1;
    @(negedge clk); load = 1'b0; conv_done = 1'b0;
    chk("R8 load wins", {6'd0, chan}, 8'd2);
    // reset mid-run returns to R1 state
    do_load(8'h47);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 reset again", {5'd0, chan, out_en}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule